// File: doc/BRIEF.md
# Configurable Event Counter Unit

This block counts hardware events for performance analysis. It holds four physical counters, each 32 bits wide, and feeds them from a bank of 64 event lines. Any physical counter can be switched at run time into two independent 16-bit halves. The unit then exposes up to eight logical counters. Every logical counter has its own control word. That word picks one event line, can invert it, and chooses between counting cycles while the line is high and counting rising edges.

A single global control word gates all counting. It holds a master enable, a freeze, a saturate-instead-of-wrap option and a privilege filter. The filter compares the current privilege level of the observed processor against a chosen level, or accepts every level. When a counter passes its top value it sets a sticky status bit. Masked status bits are ORed into one interrupt line. Reading the status word returns the bits and clears them in the same access.

Software reaches every register through a simple single-cycle write / registered-read bus.

Top module: `evt_counter_unit`

## Requirements
- R1: After reset, all registers and counters hold zero, `irq` is low and `bus_rdata` is zero.
- R2: The register map uses word addresses:
  - 0: global control.
  - 1: status.
  - 2: interrupt mask.
  - 8+k: control word of logical counter k (k = 0..7).
  - 16+n: value of physical counter n (n = 0..3).

  Global control keeps only these bits:
  - bit 31: master enable.
  - bit 30: saturate.
  - bit 24-n: 16-bit split of physical counter n.
  - bit 20: freeze.
  - bits 19:18: privilege filter.

  A control word keeps bits 31:22:
  - bits 31:26: event select.
  - bit 25: spare flag.
  - bit 24: invert.
  - bit 23: cycle mode.
  - bit 22: enable.

  Unkept bits and unmapped addresses read as zero.
- R3: With cycle mode set, a logical counter gains one per clock while its selected line, XORed with the invert bit, is high.
- R4: With cycle mode clear, a logical counter gains one per rising edge of its qualified line.
- R5: Nothing counts while the master enable is clear, while the counter's own enable is clear, or while freeze is set; counters keep their values.
- R6: The filter field passes counting when it is 3, or when it equals `priv_mode` (0 supervisor, 1 hypervisor, 2 problem).
- R7: An unsplit physical counter n that increments at all ones wraps to zero and sets status bit 31-n.
- R8: With its split bit set, physical counter n forms a low half (logical n) and a high half (logical n+4).
  - Each half is driven by its own control word.
  - Each half wraps at 16 bits, and no carry passes from the low half into the high half.
  - A wrapping half sets status bit 31-k, where k is that half's logical index.
- R9: With saturate set, a counter or half that increments at all ones keeps its value and still sets its status bit.
- R10: A status read returns the current bits and clears them, except for an overflow that arrives in the same cycle, which stays set. Writes to the status address have no effect.
- R11: `irq` is high exactly when some status bit is set whose mask bit is set. The mask uses the same bit positions as status (bit 31-k).
- R12: A bus write to a counter value replaces it, wins over an increment in the same cycle, and sets no status bit.
- R13: `bus_rdata` presents read data one cycle after `bus_rd` and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| events | input | 64 | Event lines to be counted |
| priv_mode | input | 2 | Current privilege level of the observed processor |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (5) | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the unit with its default parameters: four physical counters and a five-bit address. All eight logical counters, every split bit position and the full 64-line event select are therefore reachable. With a 32-bit counter width, preloading values near all ones through the bus brings both the 32-bit wrap and the 16-bit half wraps within a few cycles. This holds in wrap and saturate modes alike. The same preloading lets an overflow collide with a status read or with a counter write.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

    localparam int DATA_W    = 32;
    localparam int SEL_W     = 6;
    localparam int EVT_LINES = 1 << SEL_W;

    // global control bit positions
    localparam int GC_MASTER    = 31;
    localparam int GC_SAT       = 30;
    localparam int GC_SPLIT_TOP = 24;   // split bit of physical n is GC_SPLIT_TOP - n
    localparam int GC_FREEZE    = 20;
    localparam int GC_MODE_HI   = 19;
    localparam int GC_MODE_LO   = 18;

    // per-counter control word occupies the top CC_W bits
    localparam int CC_W   = SEL_W + 4;
    localparam int CC_PAD = DATA_W - CC_W;

    // register map
    localparam int ADDR_GCTL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_MASK = 2;
    localparam int CTL_BASE  = 8;
    localparam int CNT_BASE  = 16;

    typedef enum logic [1:0] {
        CM_SUPER = 2'd0,
        CM_HYPER = 2'd1,
        CM_PROB  = 2'd2,
        CM_ALL   = 2'd3
    } count_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             spare;
        logic             inv;
        logic             cyc;
        logic             en;
    } cctl_t;

endpackage

// File: rtl/ecu_event_qual.sv
module ecu_event_qual
    import ecu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_LINES-1:0] events,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 inv,
    input  logic                 cyc,
    input  logic                 en,
    input  logic                 gate_ok,
    output logic                 inc
);

    typedef struct packed {
        logic prev;
    } qst_t;

    qst_t st_d, st_q;
    logic qual;
    logic pulse;

    always_comb begin
        st_d      = st_q;
        qual      = events[sel] ^ inv;
        st_d.prev = qual;
        pulse     = cyc ? qual : (qual & ~st_q.prev);
        inc       = pulse & en & gate_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ecu_phys_counter.sv
module ecu_phys_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          split,
    input  logic          hold_max,
    input  logic          inc_lo,
    input  logic          inc_hi,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] value,
    output logic          ovf_lo,
    output logic          ovf_hi
);

    localparam int HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pst_t;

    pst_t st_d, st_q;
    logic [HW-1:0] lo_q, hi_q, lo_d, hi_d;

    always_comb begin
        st_d   = st_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        lo_q   = st_q.cnt[HW-1:0];
        hi_q   = st_q.cnt[CW-1:HW];
        lo_d   = lo_q;
        hi_d   = hi_q;
        if (wr_en) begin
            st_d.cnt = wr_val;
        end else if (!split) begin
            if (inc_lo) begin
                if (&st_q.cnt) begin
                    ovf_lo = 1'b1;
                    if (!hold_max) st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            if (inc_lo) begin
                if (&lo_q) begin
                    ovf_lo = 1'b1;
                    if (!hold_max) lo_d = '0;
                end else begin
                    lo_d = lo_q + 1'b1;
                end
            end
            if (inc_hi) begin
                if (&hi_q) begin
                    ovf_hi = 1'b1;
                    if (!hold_max) hi_d = '0;
                end else begin
                    hi_d = hi_q + 1'b1;
                end
            end
            st_d.cnt = {hi_d, lo_d};
        end
        value = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/evt_counter_unit.sv
module evt_counter_unit
    import ecu_pkg::*;
#(
    parameter int NUM_PHYS = 4,
    parameter int ADDR_W   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_LINES-1:0] events,
    input  logic [1:0]           priv_mode,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq
);

    localparam int NUM_LOG = 2 * NUM_PHYS;

    function automatic logic [DATA_W-1:0] keep_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        m[GC_MASTER]  = 1'b1;
        m[GC_SAT]     = 1'b1;
        m[GC_FREEZE]  = 1'b1;
        m[GC_MODE_HI] = 1'b1;
        m[GC_MODE_LO] = 1'b1;
        for (int n = 0; n < NUM_PHYS; n++) m[GC_SPLIT_TOP-n] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] GCTL_KEEP = keep_bits();

    typedef struct packed {
        logic [DATA_W-1:0]      gctl;
        logic [NUM_LOG-1:0]     mask;
        logic [NUM_LOG-1:0]     stat;
        cctl_t [NUM_LOG-1:0]    ctl;
        logic [DATA_W-1:0]      rdata;
    } ust_t;

    ust_t st_d, st_q;

    logic [NUM_PHYS-1:0][DATA_W-1:0] cnt_val;
    logic [NUM_PHYS-1:0]             cnt_wr;
    logic [NUM_PHYS-1:0]             split_w;
    logic [NUM_PHYS-1:0]             ovf_lo, ovf_hi;
    logic [NUM_LOG-1:0]              inc_vec;
    logic [NUM_LOG-1:0]              ovf_vec;
    logic [NUM_LOG-1:0]              stat_w;
    logic                            freeze_w;
    logic                            sat_w;
    logic                            gate_ok;
    logic [DATA_W-1:0]               rd_word;
    logic                            stat_rd;

    // gating shared by all logical counters
    always_comb begin
        freeze_w = st_q.gctl[GC_FREEZE];
        sat_w    = st_q.gctl[GC_SAT];
        gate_ok  = st_q.gctl[GC_MASTER] & ~freeze_w &
                   ((count_mode_e'(st_q.gctl[GC_MODE_HI:GC_MODE_LO]) == CM_ALL) |
                    (st_q.gctl[GC_MODE_HI:GC_MODE_LO] == priv_mode));
        stat_w   = st_q.stat;
    end

    genvar gk, gn;
    generate
        for (gk = 0; gk < NUM_LOG; gk++) begin : g_qual
            ecu_event_qual u_qual (
                .clk     (clk),
                .rst_n   (rst_n),
                .events  (events),
                .sel     (st_q.ctl[gk].sel),
                .inv     (st_q.ctl[gk].inv),
                .cyc     (st_q.ctl[gk].cyc),
                .en      (st_q.ctl[gk].en),
                .gate_ok (gate_ok),
                .inc     (inc_vec[gk])
            );
        end
        for (gn = 0; gn < NUM_PHYS; gn++) begin : g_phys
            assign split_w[gn]          = st_q.gctl[GC_SPLIT_TOP-gn];
            assign ovf_vec[gn]          = ovf_lo[gn];
            assign ovf_vec[gn+NUM_PHYS] = ovf_hi[gn];
            ecu_phys_counter #(.CW(DATA_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .split    (split_w[gn]),
                .hold_max (sat_w),
                .inc_lo   (inc_vec[gn]),
                .inc_hi   (inc_vec[gn+NUM_PHYS]),
                .wr_en    (cnt_wr[gn]),
                .wr_val   (bus_wdata),
                .value    (cnt_val[gn]),
                .ovf_lo   (ovf_lo[gn]),
                .ovf_hi   (ovf_hi[gn])
            );
        end
    endgenerate

    // register file, read mux and status
    always_comb begin
        st_d    = st_q;
        rd_word = '0;
        stat_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_STAT));

        if (bus_addr == ADDR_W'(ADDR_GCTL)) rd_word = st_q.gctl;
        if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            for (int k = 0; k < NUM_LOG; k++) rd_word[DATA_W-1-k] = st_q.stat[k];
        end
        if (bus_addr == ADDR_W'(ADDR_MASK)) begin
            for (int k = 0; k < NUM_LOG; k++) rd_word[DATA_W-1-k] = st_q.mask[k];
        end
        for (int k = 0; k < NUM_LOG; k++) begin
            if (bus_addr == ADDR_W'(CTL_BASE + k)) rd_word = {st_q.ctl[k], {CC_PAD{1'b0}}};
        end
        for (int n = 0; n < NUM_PHYS; n++) begin
            cnt_wr[n] = bus_wr && (bus_addr == ADDR_W'(CNT_BASE + n));
            if (bus_addr == ADDR_W'(CNT_BASE + n)) rd_word = cnt_val[n];
        end

        st_d.rdata = bus_rd ? rd_word : '0;
        st_d.stat  = (stat_rd ? '0 : st_q.stat) | ovf_vec;

        if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADDR_GCTL)) st_d.gctl = bus_wdata & GCTL_KEEP;
            if (bus_addr == ADDR_W'(ADDR_MASK)) begin
                for (int k = 0; k < NUM_LOG; k++) st_d.mask[k] = bus_wdata[DATA_W-1-k];
            end
            for (int k = 0; k < NUM_LOG; k++) begin
                if (bus_addr == ADDR_W'(CTL_BASE + k)) st_d.ctl[k] = bus_wdata[DATA_W-1 -: CC_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |(st_q.stat & st_q.mask);

endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
    import ecu_pkg::*;
#(
    parameter int NUM_PHYS = 4,
    parameter int ADDR_W   = 5
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_wr,
    input logic                             bus_rd,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [DATA_W-1:0]                rdata,
    input logic                             freeze,
    input logic                             sat,
    input logic [NUM_PHYS-1:0]              split,
    input logic [2*NUM_PHYS-1:0]            stat,
    input logic [2*NUM_PHYS-1:0]            ovf,
    input logic [NUM_PHYS-1:0][DATA_W-1:0]  cnt
);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(ADDR_STAT)) |=> (stat == $past(ovf))); // R10

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADDR_W'(ADDR_STAT)) |=> ((stat & $past(stat)) == $past(stat))); // R10

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (rdata == '0)); // R13

    genvar n;
    generate
        for (n = 0; n < NUM_PHYS; n++) begin : g_chk
            AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (freeze && !(bus_wr && bus_addr == ADDR_W'(CNT_BASE + n)))
                |=> $stable(cnt[n])); // R5

            AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == ADDR_W'(CNT_BASE + n))
                |=> (cnt[n] == $past(bus_wdata))); // R12

            AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (sat && !split[n] && (&cnt[n]) && !(bus_wr && bus_addr == ADDR_W'(CNT_BASE + n)))
                |=> (&cnt[n])); // R9
        end
    endgenerate

endmodule

bind evt_counter_unit ecu_checker #(.NUM_PHYS(NUM_PHYS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rdata     (bus_rdata),
    .freeze    (freeze_w),
    .sat       (sat_w),
    .split     (split_w),
    .stat      (stat_w),
    .ovf       (ovf_vec),
    .cnt       (cnt_val)
);

// File: tb/evt_counter_unit_tb.sv
`timescale 1ns/1ps
module evt_counter_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] events = '0;
    logic [1:0]  priv_mode = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    always #10 clk = ~clk;

    evt_counter_unit u_dut (
        .clk(clk), .rst_n(rst_n), .events(events), .priv_mode(priv_mode),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_gctl;
    logic [31:0] m_cnt [4];
    logic [9:0]  m_ctl [8];
    logic [7:0]  m_mask, m_stat, m_ov;
    logic        m_prev [8];
    logic        m_inc [8];
    logic [31:0] m_rw, exp_rdata;
    logic        exp_irq, m_gate, m_q;
    logic [15:0] m_half;

    function automatic logic [31:0] model_read(input logic [4:0] a);
        logic [31:0] w = '0;
        if (a == 0) w = m_gctl;
        else if (a == 1) begin for (int k = 0; k < 8; k++) w[31-k] = m_stat[k]; end
        else if (a == 2) begin for (int k = 0; k < 8; k++) w[31-k] = m_mask[k]; end
        else if (a >= 8 && a < 16) w = {m_ctl[a-8], 22'b0};
        else if (a >= 16 && a < 20) w = m_cnt[a-16];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gctl = '0; m_mask = '0; m_stat = '0;
            for (int k = 0; k < 8; k++) begin m_ctl[k] = '0; m_prev[k] = 1'b0; end
            for (int n = 0; n < 4; n++) m_cnt[n] = '0;
            exp_rdata = '0; exp_irq = 1'b0;
        end else begin
            m_rw   = model_read(bus_addr);
            m_ov   = '0;
            m_gate = m_gctl[31] && !m_gctl[20] &&
                     (m_gctl[19:18] == 2'd3 || m_gctl[19:18] == priv_mode);
            for (int k = 0; k < 8; k++) begin
                m_q = events[m_ctl[k][9:4]] ^ m_ctl[k][2];
                m_inc[k] = m_ctl[k][0] && m_gate && (m_ctl[k][1] ? m_q : (m_q && !m_prev[k]));
                m_prev[k] = m_q;
            end
            for (int n = 0; n < 4; n++) begin
                if (bus_wr && bus_addr == 5'(16 + n)) m_cnt[n] = bus_wdata;
                else if (!m_gctl[24-n]) begin
                    if (m_inc[n]) begin
                        if (m_cnt[n] == 32'hFFFF_FFFF) begin
                            m_ov[n] = 1'b1;
                            if (!m_gctl[30]) m_cnt[n] = 0;
                        end else m_cnt[n] = m_cnt[n] + 1;
                    end
                end else begin
                    for (int h = 0; h < 2; h++) begin
                        if (m_inc[n + 4*h]) begin
                            m_half = m_cnt[n][16*h +: 16];
                            if (m_half == 16'hFFFF) begin
                                m_ov[n + 4*h] = 1'b1;
                                if (!m_gctl[30]) m_half = 0;
                            end else m_half = m_half + 1;
                            m_cnt[n][16*h +: 16] = m_half;
                        end
                    end
                end
            end
            if (bus_rd && bus_addr == 5'd1) m_stat = '0;
            m_stat = m_stat | m_ov;
            if (bus_wr) begin
                if (bus_addr == 5'd0) m_gctl = bus_wdata & 32'hC1FC_0000;
                if (bus_addr == 5'd2) for (int k = 0; k < 8; k++) m_mask[k] = bus_wdata[31-k];
                if (bus_addr >= 8 && bus_addr < 16) m_ctl[bus_addr-8] = bus_wdata[31:22];
            end
            exp_rdata = bus_rd ? m_rw : '0;
            exp_irq   = |(m_stat & m_mask);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(posedge clk);
        #2;
        vectors++;
        if (bus_rdata !== exp_rdata || irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     cur_req, bus_rdata, irq, exp_rdata, exp_irq);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        bus_rd = 1'b1; bus_addr = a;
        cyc();
        bus_rd = 1'b0;
        cyc();
    endtask

    function automatic logic [31:0] cw(input int sel, input int inv, input int cy, input int en);
        return {sel[5:0], 1'b0, inv[0], cy[0], en[0], 22'b0};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        idle(2);
        rd(0); rd(1); rd(2); rd(8); rd(16);

        // R2 register map and kept bits
        cur_req = "R2";
        wr(0, 32'hFFFF_FFFF); rd(0);
        wr(0, 32'h0);
        wr(11, 32'hFFFF_FFFF); rd(11); wr(11, 0);
        wr(2, 32'hFFFF_FFFF); rd(2); wr(2, 0);
        rd(5'h1F); rd(5);

        // R3 cycle mode with and without inversion
        cur_req = "R3";
        wr(0, 32'h800C_0000);
        wr(8, cw(3, 0, 1, 1));
        events[3] = 1'b1; idle(5); events[3] = 1'b0; idle(2);
        rd(16);
        wr(9, cw(5, 1, 1, 1));
        idle(3); events[5] = 1'b1; idle(3);
        rd(17);

        // R4 edge mode
        cur_req = "R4";
        wr(10, cw(7, 0, 0, 1));
        for (int i = 0; i < 4; i++) begin
            events[7] = 1'b1; idle(2); events[7] = 1'b0; idle(1);
        end
        rd(18);

        // R5 freeze, master off, own enable off
        cur_req = "R5";
        wr(0, 32'h801C_0000);
        events[3] = 1'b1; idle(4); rd(16);
        wr(0, 32'h000C_0000); idle(3); rd(16);
        wr(0, 32'h800C_0000); wr(8, cw(3, 0, 1, 0)); idle(3); rd(16);
        wr(8, cw(3, 0, 1, 1));

        // R6 privilege filter
        cur_req = "R6";
        wr(0, 32'h8008_0000);
        priv_mode = 2'd0; idle(3); rd(16);
        priv_mode = 2'd2; idle(3); rd(16);
        wr(0, 32'h8000_0000);
        priv_mode = 2'd1; idle(2); priv_mode = 2'd0; idle(2); rd(16);

        // R7 32-bit wrap and status bit
        cur_req = "R7";
        wr(0, 32'h800C_0000);
        wr(16, 32'hFFFF_FFFD); idle(4);
        rd(16); rd(1);

        // R8 split counter halves
        cur_req = "R8";
        events[3] = 1'b0;
        wr(0, 32'h808C_0000);
        wr(13, cw(4, 0, 1, 1));
        wr(9, cw(5, 1, 1, 1));
        events[5] = 1'b0; events[4] = 1'b0;
        wr(17, 32'h0005_FFFE);
        idle(3); rd(17);
        events[5] = 1'b1; events[4] = 1'b1;
        wr(17, 32'hFFFE_0010); idle(3); rd(17); rd(1);

        // R9 saturate
        cur_req = "R9";
        events[4] = 1'b0;
        wr(0, 32'hC00C_0000);
        events[3] = 1'b1;
        wr(16, 32'hFFFF_FFFE); idle(4); rd(16); rd(1);
        wr(0, 32'hC08C_0000);
        events[4] = 1'b1; events[5] = 1'b0;
        wr(17, 32'hFFFD_FFFE); idle(4); rd(17); rd(1);
        events[4] = 1'b0; events[5] = 1'b1;

        // R10 read-clear with colliding overflow, status write ignored
        cur_req = "R10";
        wr(0, 32'h800C_0000);
        wr(16, 32'hFFFF_FFFF);
        rd(1); rd(1);
        wr(1, 32'hFFFF_FFFF); rd(1); rd(1);

        // R11 masked interrupt
        cur_req = "R11";
        wr(2, 32'h4000_0000);
        wr(16, 32'hFFFF_FFFE); idle(3);
        wr(2, 32'h8000_0000); idle(2);
        rd(1); idle(2);

        // R12 counter write versus increment
        cur_req = "R12";
        wr(16, 32'h0000_0100); rd(16);
        wr(16, 32'hFFFF_FFFF); rd(1);
        events[3] = 1'b0;

        // R13 read timing with back-to-back reads
        cur_req = "R13";
        bus_rd = 1'b1; bus_addr = 5'd0; cyc();
        bus_addr = 5'd16; cyc();
        bus_rd = 1'b0; cyc(); cyc();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule